// File: doc/BRIEF.md
# Texel Quad Cache with In-Order Return

This block is a read-only first-level cache placed between a bilinear texture filter and a memory port one level further out. The filter hands in the top-left texel coordinate of a 2x2 footprint along with an opaque state word. The cache works out the four texel addresses in a tiled texture layout, with wrap-around at the texture edge, and checks them against a two-way set-associative tag store. When a line is missing it fetches the line over a simple request/response port. It returns all four 32-bit texels in one beat, together with the state word.

Every accepted request waits in a 16-entry queue. Only the request at the head of the queue is resolved. Results therefore leave in exactly the order they arrived, and a request that would hit cannot overtake an older one that is waiting on a fill. When a texture becomes writable, a flush input clears every line. The flush takes one cycle per set. A fill that was in flight when the flush began is thrown away and fetched again.

Top module: `texel_quad_cache`

## Requirements
- R1: After reset, out_valid and mem_req_valid are low and in_ready is high.
- R2: For a request (u,v), out_texels carries the texels at (u,v), (u+1,v), (u,v+1) and (u+1,v+1), in that order in bits 31:0, 63:32, 95:64 and 127:96. Coordinates wrap modulo 2^COORD_W. Texel (x,y) lives in line {y>>2, x>>2}, with the tile row in the upper half, at word {y[1:0], x[1:0]}. Word w occupies bits 32w+31:32w of a fill response.
- R3: Results and their state words leave strictly in acceptance order. A request whose lines are all resident still waits behind an older request that is waiting on a fill.
- R4: A request whose lines are all resident causes no memory request. Back-to-back requests of that kind produce results on consecutive cycles.
- R5: On a miss the block raises mem_req_valid with the missing line index and holds both stable until mem_req_ready. At most one fill is outstanding at a time.
- R6: The queue holds 16 requests. in_ready is low while 16 requests are queued.
- R7: A one-cycle flush_req pulse drops in_ready for exactly 8 cycles, and no result is produced during that time. Every line is invalid afterwards, so re-requesting a previously resident quad fetches all of its lines again.
- R8: A fill response for a fill outstanding when a flush starts is discarded and the line is requested again. The result carries the data from the second response.
- R9: Two lines that map to the same set (set = {tile_y[0], tile_x[1:0]}) can both be resident.
- R10: When a third line is brought into a full set, it replaces the less recently used of the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_u | input | COORD_W | Quad top-left x coordinate |
| in_v | input | COORD_W | Quad top-left y coordinate |
| in_state | input | STATE_W | Opaque filter state, returned with the result |
| flush_req | input | 1 | Pulse: invalidate all lines |
| mem_req_valid | output | 1 | Line fill request |
| mem_req_ready | input | 1 | Fill request accepted |
| mem_req_line | output | 2*COORD_W-4 | Line index to fetch |
| mem_rsp_valid | input | 1 | Fill data present (one beat) |
| mem_rsp_data | input | 16*TEXEL_W | Whole line, word w at bits 32w upward |
| out_valid | output | 1 | Result present |
| out_state | output | STATE_W | State word of the returned request |
| out_texels | output | 4*TEXEL_W | The four texels of the quad |

## Verification
The bench sweeps every quad position of a 64x64 texture. This covers the texture edges, where a quad wraps to the opposite side and splits across four lines in four different sets; a design with a wrong wrap or word order returns texels from the wrong tile.

It then stresses three cases:
- A single set holding two and then three lines. A cache that picks the wrong victim refetches the recently used line instead of the stale one.
- A full queue held behind a slow fill. An off-by-one in the queue limit accepts a seventeenth request and overwrites the oldest one.
- A flush landing while a fill is in flight, with the memory answering that fill with corrupted data. A design that installs the late response returns the corrupted texels instead of fetching the line again.

// File: rtl/texel_quad_cache.sv
module texel_quad_cache #(
  parameter int COORD_W  = 6,
  parameter int STATE_W  = 8,
  parameter int TEXEL_W  = 32,
  parameter int QDEPTH_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [COORD_W-1:0]     in_u,
  input  logic [COORD_W-1:0]     in_v,
  input  logic [STATE_W-1:0]     in_state,
  input  logic                   flush_req,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  output logic [2*COORD_W-5:0]   mem_req_line,
  input  logic                   mem_rsp_valid,
  input  logic [16*TEXEL_W-1:0]  mem_rsp_data,
  output logic                   out_valid,
  output logic [STATE_W-1:0]     out_state,
  output logic [4*TEXEL_W-1:0]   out_texels
);
  localparam int TW    = COORD_W - 2;
  localparam int LAW   = 2 * TW;
  localparam int TAG_W = LAW - 3;
  localparam int SETS  = 8;
  localparam int QD    = 1 << QDEPTH_W;

  typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT} fill_t;

  logic [16*TEXEL_W-1:0] line_q [2*SETS];
  logic [TAG_W-1:0]      tag_q  [2*SETS];
  logic [2*SETS-1:0]     vld_q;
  logic [SETS-1:0]       lru_q;

  logic [COORD_W-1:0] qu [QD];
  logic [COORD_W-1:0] qv [QD];
  logic [STATE_W-1:0] qs [QD];
  logic [QDEPTH_W-1:0] wp, rp;
  logic [QDEPTH_W:0]   cnt;

  logic       flush_act;
  logic [2:0] fcnt;
  fill_t      fst;
  logic       stale;
  logic [LAW-1:0] fill_line;

  logic [2:0]         set_i [4];
  logic               way_i [4];
  logic [3:0]         hit;
  logic [TEXEL_W-1:0] tx_i  [4];
  logic [LAW-1:0]     miss_line;

  always_comb begin
    logic [COORD_W-1:0] x, y;
    logic [LAW-1:0] l;
    logic [TAG_W-1:0] t;
    logic h0, h1;
    miss_line = '0;
    for (int i = 3; i >= 0; i--) begin
      x = qu[rp] + COORD_W'(i % 2);
      y = qv[rp] + COORD_W'(i / 2);
      l = {y[COORD_W-1:2], x[COORD_W-1:2]};
      set_i[i] = {l[TW], l[1:0]};
      t = {l[LAW-1:TW+1], l[TW-1:2]};
      h0 = vld_q[{1'b0, set_i[i]}] && (tag_q[{1'b0, set_i[i]}] == t);
      h1 = vld_q[{1'b1, set_i[i]}] && (tag_q[{1'b1, set_i[i]}] == t);
      hit[i] = h0 | h1;
      way_i[i] = ~h0;
      tx_i[i] = line_q[{way_i[i], set_i[i]}][{y[1:0], x[1:0]}*TEXEL_W +: TEXEL_W];
      if (!hit[i]) miss_line = l;
    end
  end

  wire [2:0]       fset    = {fill_line[TW], fill_line[1:0]};
  wire [TAG_W-1:0] ftag    = {fill_line[LAW-1:TW+1], fill_line[TW-1:2]};
  wire             fway    = !vld_q[{1'b0, fset}] ? 1'b0 :
                             (!vld_q[{1'b1, fset}] ? 1'b1 : lru_q[fset]);
  wire             install = (fst == F_WAIT) && mem_rsp_valid && !stale;
  wire             head_ok = (cnt != '0);
  wire             pop     = head_ok && (&hit) && !flush_act;
  wire             need    = head_ok && !(&hit) && !flush_act && !flush_req;
  wire             push    = in_valid && in_ready;
  wire             flush_go = flush_req && !flush_act;

  assign in_ready      = (cnt != (QDEPTH_W+1)'(QD)) && !flush_act;
  assign mem_req_valid = (fst == F_REQ);
  assign mem_req_line  = fill_line;

  always_ff @(posedge clk) begin
    if (push) begin
      qu[wp] <= in_u;
      qv[wp] <= in_v;
      qs[wp] <= in_state;
    end
    if (install) begin
      line_q[{fway, fset}] <= mem_rsp_data;
      tag_q[{fway, fset}]  <= ftag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
      vld_q <= '0; lru_q <= '0;
      flush_act <= 1'b0; fcnt <= '0;
      fst <= F_IDLE; stale <= 1'b0; fill_line <= '0;
      out_valid <= 1'b0; out_state <= '0; out_texels <= '0;
    end else begin
      wp  <= wp + QDEPTH_W'(push);
      rp  <= rp + QDEPTH_W'(pop);
      cnt <= cnt + (QDEPTH_W+1)'(push) - (QDEPTH_W+1)'(pop);
      out_valid <= pop;
      if (pop) begin
        out_state  <= qs[rp];
        out_texels <= {tx_i[3], tx_i[2], tx_i[1], tx_i[0]};
        for (int i = 0; i < 4; i++) lru_q[set_i[i]] <= ~way_i[i];
      end
      if (install) begin
        vld_q[{fway, fset}] <= 1'b1;
        lru_q[fset] <= ~fway;
      end
      if (flush_act) begin
        vld_q[{1'b0, fcnt}] <= 1'b0;
        vld_q[{1'b1, fcnt}] <= 1'b0;
        fcnt <= fcnt + 3'd1;
        if (fcnt == 3'd7) flush_act <= 1'b0;
      end else if (flush_req) begin
        flush_act <= 1'b1;
        fcnt <= '0;
      end
      case (fst)
        F_IDLE: if (need) begin
          fst <= F_REQ;
          fill_line <= miss_line;
          stale <= 1'b0;
        end
        F_REQ:  if (mem_req_ready) fst <= F_WAIT;
        F_WAIT: if (mem_rsp_valid) fst <= F_IDLE;
        default: fst <= F_IDLE;
      endcase
      if (flush_go && fst != F_IDLE) stale <= 1'b1;
    end
  end
endmodule

// File: rtl/texel_quad_cache_chk.sv
module texel_quad_cache_chk #(
  parameter int LAW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic           flush_act,
  input logic           mem_req_valid,
  input logic           mem_req_ready,
  input logic [LAW-1:0] mem_req_line,
  input logic           mem_rsp_valid,
  input logic           out_valid
);
  logic [7:0] pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else pend <= pend + 8'(in_valid && in_ready) - 8'(out_valid);
  end

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_line));

  p_rsp_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> !mem_req_valid);

  p_busy_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_act |-> !in_ready);

  p_quiet_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_act |=> !out_valid);

  p_in_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> pend != 8'd0);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pend > 8'd16 |-> !in_ready);
endmodule

bind texel_quad_cache texel_quad_cache_chk #(.LAW(2*COORD_W-4)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .flush_act(flush_act), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_line(mem_req_line),
  .mem_rsp_valid(mem_rsp_valid), .out_valid(out_valid)
);

// File: tb/sim_texel_quad_cache.sv
module sim_texel_quad_cache;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [5:0] in_u = '0, in_v = '0;
  logic [7:0] in_state = '0;
  logic flush_req = 1'b0;
  logic mem_req_valid, mem_req_ready;
  logic [7:0] mem_req_line;
  logic mem_rsp_valid;
  logic [511:0] mem_rsp_data;
  logic out_valid;
  logic [7:0] out_state;
  logic [127:0] out_texels;

  always #2 clk = ~clk;

  texel_quad_cache u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_u(in_u), .in_v(in_v), .in_state(in_state), .flush_req(flush_req),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_line(mem_req_line), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .out_valid(out_valid),
    .out_state(out_state), .out_texels(out_texels)
  );

  int checks = 0, errors = 0;
  int sent = 0, out_cnt = 0, cyc = 0, fills = 0;
  int long_lat = 0;
  bit corrupt_next = 1'b0;
  logic [7:0] last_line = '0;
  logic [5:0] exp_u [8192];
  logic [5:0] exp_v [8192];
  logic [7:0] exp_s [8192];
  int out_cyc [8192];

  function automatic logic [31:0] tword(input logic [7:0] l, input logic [3:0] w);
    return {l, w, w, ~l, w, 4'hC};
  endfunction
  function automatic logic [31:0] tex(input logic [5:0] x, input logic [5:0] y);
    return tword({y[5:2], x[5:2]}, {y[1:0], x[1:0]});
  endfunction
  function automatic logic [127:0] quad(input logic [5:0] u, input logic [5:0] v);
    logic [5:0] u1, v1;
    u1 = u + 6'd1;
    v1 = v + 6'd1;
    return {tex(u1, v1), tex(u, v1), tex(u1, v), tex(u, v)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      chk(out_texels == quad(exp_u[out_cnt], exp_v[out_cnt]), "R2 quad texels (R8 after stale fill)",
          out_texels, quad(exp_u[out_cnt], exp_v[out_cnt]));
      chk(out_state == exp_s[out_cnt], "R3 order of state", 128'(out_state), 128'(exp_s[out_cnt]));
      out_cyc[out_cnt] = cyc;
      out_cnt++;
    end
  end

  initial begin
    logic [7:0] lfsr;
    logic [7:0] ln;
    int lat;
    lfsr = 8'h5B;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (rst_n && mem_req_valid) begin
        mem_req_ready = 1'b1;
        ln = mem_req_line;
        last_line = ln;
        fills++;
        lat = (long_lat != 0) ? long_lat : 1 + int'(lfsr[2:0]);
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (lat - 1) @(negedge clk);
        for (int w = 0; w < 16; w++) mem_rsp_data[32*w +: 32] = tword(ln, 4'(w));
        if (corrupt_next) begin
          mem_rsp_data = ~mem_rsp_data;
          corrupt_next = 1'b0;
        end
        mem_rsp_valid = 1'b1;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    finish_run();
  end

  task automatic send(input logic [5:0] u, input logic [5:0] v, input logic [7:0] s);
    while (!in_ready) @(negedge clk);
    in_u = u; in_v = v; in_state = s; in_valid = 1'b1;
    exp_u[sent] = u; exp_v[sent] = v; exp_s[sent] = s;
    sent++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain;
    while (out_cnt < sent) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_flush;
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
  endtask

  task automatic flush_wait;
    pulse_flush();
    repeat (10) @(negedge clk);
  endtask

  initial begin
    int f0, lows;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid, "R1 out_valid after reset", 128'(out_valid), 128'(0));
    chk(in_ready, "R1 in_ready after reset", 128'(in_ready), 128'(1));
    chk(!mem_req_valid, "R1 mem_req_valid after reset", 128'(mem_req_valid), 128'(0));

    for (int v = 0; v < 64; v++)
      for (int u = 0; u < 64; u++)
        send(6'(u), 6'(v), 8'(u ^ (v << 2)));
    drain();

    // R4: the last quad's lines are resident
    f0 = fills;
    for (int k = 0; k < 8; k++) send(6'd63, 6'd63, 8'(8'hE0 + k));
    drain();
    chk(fills == f0, "R4 no fetch on resident quad", 128'(fills - f0), 128'(0));
    chk(out_cyc[sent-1] - out_cyc[sent-8] == 7, "R4 one hit per cycle",
        128'(out_cyc[sent-1] - out_cyc[sent-8]), 128'(7));

    // R7: flush timing and invalidation
    pulse_flush();
    lows = 0;
    for (int k = 0; k < 12; k++) begin
      if (!in_ready) lows++;
      @(negedge clk);
    end
    chk(lows == 8, "R7 in_ready low cycles", 128'(lows), 128'(8));
    f0 = fills;
    send(6'd63, 6'd63, 8'h77);
    drain();
    chk(fills - f0 == 4, "R7 refetch after flush", 128'(fills - f0), 128'(4));

    // R9/R10: tiles (0,0),(4,0),(8,0) share set 0
    flush_wait();
    f0 = fills;
    send(6'd0, 6'd0, 8'h01); drain();
    chk(fills - f0 == 1 && last_line == 8'h00, "R5 fill line index A", 128'(last_line), 128'(8'h00));
    send(6'd16, 6'd0, 8'h02); drain();
    chk(fills - f0 == 2 && last_line == 8'h04, "R5 fill line index B", 128'(last_line), 128'(8'h04));
    send(6'd0, 6'd0, 8'h03); drain();
    chk(fills - f0 == 2, "R9 both ways resident", 128'(fills - f0), 128'(2));
    send(6'd32, 6'd0, 8'h04); drain();
    chk(fills - f0 == 3 && last_line == 8'h08, "R10 third line fetched", 128'(last_line), 128'(8'h08));
    send(6'd0, 6'd0, 8'h05); drain();
    chk(fills - f0 == 3, "R10 recent line kept", 128'(fills - f0), 128'(3));
    send(6'd16, 6'd0, 8'h06); drain();
    chk(fills - f0 == 4, "R10 older line evicted", 128'(fills - f0), 128'(4));

    // R6: queue fills behind a slow miss
    long_lat = 60;
    f0 = out_cnt;
    for (int k = 0; k < 16; k++) send(6'd40, 6'd40, 8'(8'h90 + k));
    chk(!in_ready, "R6 in_ready low with 16 queued", 128'(in_ready), 128'(0));
    chk(out_cnt == f0, "R3 no result while head misses", 128'(out_cnt - f0), 128'(0));
    send(6'd41, 6'd40, 8'hA5);
    long_lat = 0;
    drain();

    // R8: stale fill dropped
    flush_wait();
    long_lat = 6;
    corrupt_next = 1'b1;
    f0 = fills;
    send(6'd8, 6'd8, 8'h5C);
    while (fills == f0) @(negedge clk);
    pulse_flush();
    long_lat = 0;
    drain();
    chk(fills - f0 == 2, "R8 line refetched after flush", 128'(fills - f0), 128'(2));
    chk(out_cnt == sent, "R8 result delivered", 128'(out_cnt), 128'(sent));

    finish_run();
  end
endmodule